// File: doc/BRIEF.md
# Dual-Pattern Overlapping Serial Detector

This block watches a one-bit serial stream and raises a flag whenever the three most recently sampled bits spell either `110` or `101`. The stream is sampled on every rising clock edge. Matches may overlap, and the tail of one match can serve as the head of the next. For example, in `1101` the `110` match ends on the third bit and a `101` match ends on the fourth bit.

The block is a Moore machine. The flag comes only from the registered state, through a combinational decoder with no extra register. The flag is therefore valid in the clock cycle that follows the edge that sampled the third bit of a pattern, and it cannot be changed by the input between edges. The design is split into three pieces: next-state logic, the state register and the output decoder. A synchronous active-high reset discards everything seen so far. The input is assumed to be synchronous to the clock already.

Top module: `dual_seq_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to its idle state, and `flag_o` is 0 in the following cycle. After reset is released, `flag_o` stays 0 until at least three new bits have been sampled.
- R2: After the edge that samples the last bit of the sequence 1,1,0 (oldest first), `flag_o` is 1 for the cycle that follows that edge.
- R3: After the edge that samples the last bit of the sequence 1,0,1 (oldest first), `flag_o` is 1 for the cycle that follows that edge.
- R4: For the other six three-bit histories (000, 001, 010, 011, 100 and 111, oldest first), `flag_o` is 0.
- R5: Overlapping matches are all reported. In `1101`, `flag_o` is 1 after both the third and the fourth bit. In `101101`, `flag_o` is 1 after bits 3, 5 and 6.
- R6: `flag_o` is a function of the registered state only. A change on `din` between rising edges leaves `flag_o` unchanged until the next edge.
- R7: Bits sampled before a reset never take part in a later match. For example, `1`,`1`, then reset, then `0` leaves `flag_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| flag_o | output | 1 | High while the last three sampled bits are 110 or 101 |

## Verification
The bench targets overlap chains, where one match has to hand its suffix to the other pattern. A machine that fell back to idle after a hit would drop the second flag of `1101` or the later flags of `101101`. It checks that a reset in the middle of a partial match discards that prefix; a machine that kept the old history would flag a spurious `110` right after reset. It also toggles `din` between edges while the flag is high. A design that decoded the flag from the input, as a Mealy machine does, would change the flag mid-cycle. Finally, a long random stream is compared against a three-bit history model, which exposes any wrong transition and any flag that arrives a cycle early or late.

// File: rtl/seqdet_pkg.sv
`timescale 1ns/1ps
package seqdet_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_ONES  = 3'd2,
        ST_ONEZ  = 3'd3,
        ST_HIT_A = 3'd4,   // history ends in 1,1,0
        ST_HIT_B = 3'd5    // history ends in 1,0,1
    } seq_state_e;

    function automatic logic state_is_hit(input seq_state_e s);
        return (s == ST_HIT_A) || (s == ST_HIT_B);
    endfunction

endpackage

// File: rtl/seqdet_next.sv
`timescale 1ns/1ps
module seqdet_next
    import seqdet_pkg::*;
(
    input  seq_state_e cur_s,
    input  logic       bit_i,
    output seq_state_e nxt_s
);
    always_comb begin
        nxt_s = ST_IDLE;
        unique case (cur_s)
            ST_IDLE:  nxt_s = bit_i ? ST_ONE   : ST_IDLE;
            ST_ONE:   nxt_s = bit_i ? ST_ONES  : ST_ONEZ;
            ST_ONES:  nxt_s = bit_i ? ST_ONES  : ST_HIT_A;
            ST_ONEZ:  nxt_s = bit_i ? ST_HIT_B : ST_IDLE;
            ST_HIT_A: nxt_s = bit_i ? ST_HIT_B : ST_IDLE;
            ST_HIT_B: nxt_s = bit_i ? ST_ONES  : ST_ONEZ;
            default:  nxt_s = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/seqdet_state_reg.sv
`timescale 1ns/1ps
module seqdet_state_reg
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e nxt_s,
    output seq_state_e cur_s
);
    always_ff @(posedge clk) begin
        if (rst) cur_s <= ST_IDLE;
        else     cur_s <= nxt_s;
    end

    // R1: the first cycle after reset is released sits in idle
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cur_s == ST_IDLE);
endmodule

// File: rtl/seqdet_out_dec.sv
`timescale 1ns/1ps
module seqdet_out_dec
    import seqdet_pkg::*;
(
    input  seq_state_e cur_s,
    output logic       hit_o
);
    always_comb begin
        hit_o = 1'b0;
        if (state_is_hit(cur_s)) hit_o = 1'b1;
    end
endmodule

// File: rtl/dual_seq_detector.sv
`timescale 1ns/1ps
module dual_seq_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic flag_o
);
    seq_state_e state_q;
    seq_state_e state_d;

    seqdet_next u_next (
        .cur_s (state_q),
        .bit_i (din),
        .nxt_s (state_d)
    );

    seqdet_state_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .nxt_s (state_d),
        .cur_s (state_q)
    );

    seqdet_out_dec u_dec (
        .cur_s (state_q),
        .hit_o (flag_o)
    );

    // R2: a 0 arriving after two ones flags in the next cycle
    assert_flag_110_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONES && !din) |=> flag_o);

    // R3: a 1 arriving after 1,0 flags in the next cycle
    assert_flag_101_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONEZ && din) |=> flag_o);

    // R4: history 1,0,0 never flags
    assert_no_flag_100_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONEZ && !din) |=> !flag_o);

    // R5: a 110 hit followed by a 1 chains into a 101 hit
    assert_overlap_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_o && state_q == ST_HIT_A && din) |=> flag_o);
endmodule

// File: tb/dual_seq_detector_tb_top.sv
`timescale 1ns/1ps
module dual_seq_detector_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic w   = 1'b0;
    logic z;

    int total = 0;
    int bad   = 0;
    logic [2:0] hist = 3'b000;
    int cnt = 0;

    always #2 clk = ~clk;

    dual_seq_detector dut_i (
        .clk    (clk),
        .rst    (rst),
        .din    (w),
        .flag_o (z)
    );

    // {input bit, expected flag after that bit}, stream starts right after reset
    localparam int NVEC = 20;
    localparam logic [1:0] VEC [NVEC] = '{
        2'b10, 2'b10, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b01, 2'b11, 2'b00,
        2'b00, 2'b10, 2'b00, 2'b11, 2'b10, 2'b10, 2'b01, 2'b00, 2'b00, 2'b10
    };

    function automatic logic model_exp();
        return (cnt >= 3) && (hist == 3'b110 || hist == 3'b101);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: z=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        w = b;
        @(posedge clk);
        hist = {hist[1:0], b};
        if (cnt < 3) cnt++;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        w   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        hist = 3'b000;
        cnt  = 0;
    endtask

    function automatic string tag_for(input logic exp_z);
        if (exp_z && hist == 3'b110) return "R2";
        if (exp_z) return "R3";
        return "R4";
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: z=%b expected finish", z);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 reset", z, 1'b0);

        // table walk: expected values written from the requirements
        for (int i = 0; i < NVEC; i++) begin
            drive_bit(VEC[i][1]);
            check(tag_for(VEC[i][0]), z, VEC[i][0]);
            if (model_exp() !== VEC[i][0])
                $display("note: table entry %0d disagrees with history model", i);
        end

        // R5: overlap 1101
        do_reset();
        drive_bit(1'b1); check("R5 1101 b1", z, 1'b0);
        drive_bit(1'b1); check("R5 1101 b2", z, 1'b0);
        drive_bit(1'b0); check("R5 1101 b3", z, 1'b1);
        drive_bit(1'b1); check("R5 1101 b4", z, 1'b1);

        // R5: overlap 101101
        do_reset();
        drive_bit(1'b1); check("R5 101101 b1", z, 1'b0);
        drive_bit(1'b0); check("R5 101101 b2", z, 1'b0);
        drive_bit(1'b1); check("R5 101101 b3", z, 1'b1);
        drive_bit(1'b1); check("R5 101101 b4", z, 1'b0);
        drive_bit(1'b0); check("R5 101101 b5", z, 1'b1);
        drive_bit(1'b1); check("R5 101101 b6", z, 1'b1);

        // R6: toggling w between edges while flagged leaves z alone
        do_reset();
        drive_bit(1'b1);
        drive_bit(1'b1);
        drive_bit(1'b0);
        check("R6 flagged", z, 1'b1);
        w = 1'b1; #0.5;
        check("R6 w->1 mid-cycle", z, 1'b1);
        w = 1'b0; #0.5;
        check("R6 w->0 mid-cycle", z, 1'b1);
        // and while not flagged
        drive_bit(1'b0);
        check("R6 unflagged", z, 1'b0);
        w = 1'b1; #0.5;
        check("R6 w->1 unflagged", z, 1'b0);

        // R7: prefix before reset is discarded
        do_reset();
        drive_bit(1'b1);
        drive_bit(1'b1);
        do_reset();
        check("R1 reset mid-stream", z, 1'b0);
        drive_bit(1'b0); check("R7 stale 11 then 0", z, 1'b0);
        drive_bit(1'b1); check("R7 after 01", z, 1'b0);
        drive_bit(1'b0); check("R7 after 010", z, 1'b0);

        // R1: reset asserted while flagged
        do_reset();
        drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b1);
        check("R3 before reset", z, 1'b1);
        do_reset();
        check("R1 reset clears flag", z, 1'b0);

        // random stream against the history model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic b;
            b = 1'($urandom_range(0, 1));
            drive_bit(b);
            check(model_exp() ? ((hist == 3'b110) ? "R2 rand" : "R3 rand") : "R4 rand",
                  z, model_exp());
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule